// File: doc/BRIEF.md
# Interrupt Group Assignment Register Bank

This block stores the group assignment of every interrupt line handled by a multi-core interrupt distributor. Each interrupt carries one bit. A value of 1 places the interrupt in Group 1, the non-secure group. A value of 0 places it in Group 0, the secure group. Software reaches these bits over a byte-wide register bus. Each access carries an address offset, write data, read and write strobes, a secure attribute and the index of the CPU that issued it. The block returns registered read data and an error flag one cycle after the strobe.

The first 32 interrupts are private to each core, so every core holds its own copy of their group bits. An access only ever sees the copy that belongs to the requesting CPU. The remaining interrupts are shared: one bit serves all cores, and a write to it takes effect for every core at once. Two configuration inputs decide whether the group bits are visible at all: the architecture revision and the presence of the security extension. A flat output vector presents each interrupt's group as seen by each core, for use by the downstream priority logic.

Top module: `igrp_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every group bit is cleared to Group 0. After that edge, `bus_rdata` is 0 and `bus_err` is 0.
- R2: Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe. In any cycle that does not follow a read, `bus_rdata` is 0.
- R3: Byte offset 0x80+k holds interrupts 8k to 8k+7, with bit i belonging to interrupt 8k+i. A written 1 selects Group 1 and a written 0 selects Group 0. A later read returns the stored value.
- R4: Group bits exist only when `cfg_arch_rev` equals 2 or `cfg_sec_ext` is 1. Without them, any access at offset 0x80 or above reads 0, changes nothing and raises no error.
- R5: When `cfg_sec_ext` is 1, an access with `bus_secure` = 0 at offset 0x80 or above reads 0, changes nothing and raises no error. Secure accesses work normally.
- R6: Interrupts 0 to 31 (offsets 0x80 to 0x83) keep one bit per CPU. A read or write touches only the copy of CPU `bus_cpu`, and the other CPUs' copies are left unchanged.
- R7: Interrupts 32 and above keep a single bit. A write by any CPU changes that bit for all CPUs, and a read by any CPU returns it.
- R8: An access raises `bus_err` in the cycle after its strobe, with read data 0 and no state change, in two cases. The first is an offset below 0x80. The second is an access that is otherwise permitted, at an offset of 0x80 + NUM_IRQ/8 or above. Without a read or write strobe, `bus_err` is 0 in the following cycle.
- R9: `grp_view` bit c*NUM_IRQ+n is the group of interrupt n as seen by CPU c. It reflects a write in the cycle after the write strobe.
- R10: When `bus_rd` and `bus_wr` are both high for the same byte, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_arch_rev | input | 4 | Architecture revision; value 2 enables groups |
| cfg_sec_ext | input | 1 | Security extension present |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 8 | Write data, one bit per interrupt |
| bus_secure | input | 1 | Access is secure |
| bus_cpu | input | max(1,clog2(NUM_CPU)) | Index of the requesting CPU |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | Registered bad-access flag |
| grp_view | output | NUM_CPU*NUM_IRQ | Group of each interrupt as seen by each CPU |

## Verification
The bench builds the block with NUM_CPU = 4 and NUM_IRQ = 96. Four separate private banks make it possible to see that a write by one core leaves the others alone. Eight shared bytes, from 0x84 to 0x8B, let the last implemented byte and the first byte past it (0x8C) both be reached. With three CPUs writing and reading the same offsets, mixing up banked and shared handling shows up directly in `grp_view` and in the read data.

// File: rtl/igrp_pkg.sv
package igrp_pkg;
  localparam int unsigned PRIV_IRQS     = 32;
  localparam int unsigned IRQS_PER_BYTE = 8;
  localparam int unsigned PRIV_BYTES    = PRIV_IRQS / IRQS_PER_BYTE;
  localparam int unsigned GRP_BASE_OFF  = 'h80;
  localparam logic [3:0]  GRP_REV       = 4'd2;

  typedef struct packed {
    logic hit;   // permitted access to an implemented byte
    logic priv;  // byte belongs to the per-CPU range
    logic bad;   // access must be flagged as an error
  } igrp_dec_t;
endpackage

// File: rtl/igrp_decode.sv
module igrp_decode
  import igrp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        arch_rev,
  input  logic              sec_ext,
  input  logic              secure,
  output igrp_dec_t         dec,
  output logic [ADDR_W-1:0] byte_idx
);
  localparam int unsigned NUM_BYTES = NUM_IRQ / IRQS_PER_BYTE;

  logic has_groups;
  logic allowed;
  logic in_win;
  logic in_impl;

  always_comb begin
    has_groups = (arch_rev == GRP_REV) || sec_ext;
    allowed    = has_groups && !(sec_ext && !secure);
    in_win     = addr >= ADDR_W'(GRP_BASE_OFF);
    byte_idx   = addr - ADDR_W'(GRP_BASE_OFF);
    in_impl    = byte_idx < ADDR_W'(NUM_BYTES);
    dec.bad    = !in_win || (allowed && !in_impl);
    dec.hit    = in_win && allowed && in_impl;
    dec.priv   = byte_idx < ADDR_W'(PRIV_BYTES);
  end
endmodule

// File: rtl/igrp_priv_bank.sv
module igrp_priv_bank
  import igrp_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 2,
  parameter int unsigned SEL_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             sel,
  input  logic [CPU_W-1:0]             cpu,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rdata,
  output logic [NUM_CPU*PRIV_IRQS-1:0] view
);
  logic [7:0] bank_q [NUM_CPU][PRIV_BYTES];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int b = 0; b < PRIV_BYTES; b++) bank_q[c][b] <= '0;
      end else if (wr_en && (cpu == CPU_W'(c))) begin
        bank_q[c][sel] <= wdata;
      end
    end
    for (genvar b = 0; b < PRIV_BYTES; b++) begin : g_byte
      assign view[c*PRIV_IRQS + b*IRQS_PER_BYTE +: IRQS_PER_BYTE] = bank_q[c][b];
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu == CPU_W'(c)) rdata = bank_q[c][sel];
    end
  end
endmodule

// File: rtl/igrp_shared_bank.sv
module igrp_shared_bank #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [NUM_BYTES*8-1:0] view
);
  logic [7:0] mem_q [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BYTES; b++) mem_q[b] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_view
    assign view[b*8 +: 8] = mem_q[b];
  end
endmodule

// File: rtl/igrp_bank.sv
module igrp_bank
  import igrp_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [3:0]                 cfg_arch_rev,
  input  logic                       cfg_sec_ext,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [7:0]                 bus_wdata,
  input  logic                       bus_secure,
  input  logic [CPU_W-1:0]           bus_cpu,
  output logic [7:0]                 bus_rdata,
  output logic                       bus_err,
  output logic [NUM_CPU*NUM_IRQ-1:0] grp_view
);
  localparam int unsigned SEL_W         = $clog2(PRIV_BYTES);
  localparam int unsigned NUM_SHR_IRQ   = NUM_IRQ - PRIV_IRQS;
  localparam int unsigned NUM_SHR_BYTES = NUM_SHR_IRQ / IRQS_PER_BYTE;
  localparam int unsigned SHR_IDX_W     = (NUM_SHR_BYTES > 1) ? $clog2(NUM_SHR_BYTES) : 1;

  igrp_dec_t              dec;
  logic [ADDR_W-1:0]      byte_idx;
  logic                   wr_priv;
  logic [7:0]             rd_priv;
  logic [7:0]             rd_shr;
  logic [7:0]             rd_val;
  logic [NUM_CPU*PRIV_IRQS-1:0] priv_view;

  igrp_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) dec_i (
    .addr     (bus_addr),
    .arch_rev (cfg_arch_rev),
    .sec_ext  (cfg_sec_ext),
    .secure   (bus_secure),
    .dec      (dec),
    .byte_idx (byte_idx)
  );

  assign wr_priv = bus_wr && dec.hit && dec.priv;

  igrp_priv_bank #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SEL_W(SEL_W)) priv_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_priv),
    .sel   (byte_idx[SEL_W-1:0]),
    .cpu   (bus_cpu),
    .wdata (bus_wdata),
    .rdata (rd_priv),
    .view  (priv_view)
  );

  if (NUM_SHR_BYTES > 0) begin : g_shr
    logic                      wr_shr;
    logic [ADDR_W-1:0]         shr_off;
    logic [NUM_SHR_IRQ-1:0]    shr_view;

    assign wr_shr  = bus_wr && dec.hit && !dec.priv;
    assign shr_off = byte_idx - ADDR_W'(PRIV_BYTES);

    igrp_shared_bank #(.NUM_BYTES(NUM_SHR_BYTES), .IDX_W(SHR_IDX_W)) shr_i (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_shr),
      .idx   (shr_off[SHR_IDX_W-1:0]),
      .wdata (bus_wdata),
      .rdata (rd_shr),
      .view  (shr_view)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cview
      assign grp_view[c*NUM_IRQ + PRIV_IRQS +: NUM_SHR_IRQ] = shr_view;
    end
  end else begin : g_noshr
    assign rd_shr = '0;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_pview
    assign grp_view[c*NUM_IRQ +: PRIV_IRQS] = priv_view[c*PRIV_IRQS +: PRIV_IRQS];
  end

  always_comb begin
    if (!dec.hit)     rd_val = '0;
    else if (dec.priv) rd_val = rd_priv;
    else               rd_val = rd_shr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : 8'h00;
      bus_err   <= (bus_rd || bus_wr) && dec.bad;
    end
  end
endmodule

// File: rtl/igrp_bank_chk.sv
module igrp_bank_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CPU_W   = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [3:0]                 cfg_arch_rev,
  input logic                       cfg_sec_ext,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [7:0]                 bus_wdata,
  input logic                       bus_secure,
  input logic [CPU_W-1:0]           bus_cpu,
  input logic [7:0]                 bus_rdata,
  input logic                       bus_err,
  input logic [NUM_CPU*NUM_IRQ-1:0] grp_view
);
  logic rst_seen_q = 1'b0;
  logic unused_ok;
  assign unused_ok = ^bus_wdata;

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: one cycle after a reset edge everything is clear
  always @(negedge clk) begin
    if (rst_seen_q) begin
      p_reset_clear_r1: assert (grp_view == '0 && bus_rdata == 8'h00 && !bus_err);
    end
  end

  p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 8'h00);

  p_low_addr_err_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) && bus_addr < ADDR_W'('h80) |=> bus_err);

  p_err_needs_access_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |=> !bus_err);

  p_nogroups_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_arch_rev != 4'd2) && !cfg_sec_ext && (bus_rd || bus_wr) && bus_addr >= ADDR_W'('h80)
    |=> bus_rdata == 8'h00 && !bus_err && $stable(grp_view));

  p_nonsecure_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_sec_ext && !bus_secure && (bus_rd || bus_wr) && bus_addr >= ADDR_W'('h80)
    |=> bus_rdata == 8'h00 && !bus_err && $stable(grp_view));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_iso
    p_bank_isolate_r6: assert property (@(posedge clk) disable iff (rst)
      bus_wr && (bus_cpu != CPU_W'(c)) |=> $stable(grp_view[c*NUM_IRQ +: 32]));
  end
endmodule

bind igrp_bank igrp_bank_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_IRQ (NUM_IRQ),
  .ADDR_W  (ADDR_W),
  .CPU_W   (CPU_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_arch_rev (cfg_arch_rev),
  .cfg_sec_ext  (cfg_sec_ext),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_secure   (bus_secure),
  .bus_cpu      (bus_cpu),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .grp_view     (grp_view)
);

// File: tb/igrp_bank_tb_top.sv
module igrp_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 4;
  localparam int NUM_IRQ    = 96;
  localparam int ADDR_W     = 12;
  localparam int CPU_W      = 2;
  localparam int NUM_BYTES  = NUM_IRQ / 8;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic [3:0]                 cfg_arch_rev = 4'd2;
  logic                       cfg_sec_ext = 1'b0;
  logic                       bus_rd = 1'b0;
  logic                       bus_wr = 1'b0;
  logic [ADDR_W-1:0]          bus_addr = '0;
  logic [7:0]                 bus_wdata = '0;
  logic                       bus_secure = 1'b0;
  logic [CPU_W-1:0]           bus_cpu = '0;
  logic [7:0]                 bus_rdata;
  logic                       bus_err;
  logic [NUM_CPU*NUM_IRQ-1:0] grp_view;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  logic model [NUM_CPU][NUM_IRQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  igrp_bank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_arch_rev(cfg_arch_rev), .cfg_sec_ext(cfg_sec_ext),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_secure(bus_secure), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .grp_view(grp_view)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit accessible(input bit sec);
    return ((cfg_arch_rev == 4'd2) || cfg_sec_ext) && !(cfg_sec_ext && !sec);
  endfunction

  function automatic bit exp_bad(input bit sec, input int addr);
    return (addr < 'h80) || (accessible(sec) && (addr - 'h80) >= NUM_BYTES);
  endfunction

  function automatic logic [7:0] model_byte(input int cpu, input int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = model[cpu][8*k + i];
    return v;
  endfunction

  task automatic access(input bit rd, input bit wr, input int cpu, input bit sec,
                        input int addr, input logic [7:0] wd,
                        output logic [7:0] rdo, output logic erro);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_cpu = CPU_W'(cpu); bus_secure = sec;
    bus_addr = ADDR_W'(addr); bus_wdata = wd;
    @(negedge clk);
    rdo = bus_rdata; erro = bus_err;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic model_write(input int cpu, input bit sec, input int addr, input logic [7:0] wd);
    int k;
    if (!accessible(sec) || exp_bad(sec, addr)) return;
    k = addr - 'h80;
    for (int i = 0; i < 8; i++) begin
      if (8*k + i < 32) model[cpu][8*k + i] = wd[i];
      else for (int c = 0; c < NUM_CPU; c++) model[c][8*k + i] = wd[i];
    end
  endtask

  function automatic logic [7:0] model_read(input int cpu, input bit sec, input int addr);
    if (!accessible(sec) || exp_bad(sec, addr)) return 8'h00;
    return model_byte(cpu, addr - 'h80);
  endfunction

  task automatic wr_chk(input string req, input int cpu, input bit sec, input int addr, input logic [7:0] wd);
    logic [7:0] r; logic e; bit be;
    be = exp_bad(sec, addr);
    model_write(cpu, sec, addr, wd);
    access(1'b0, 1'b1, cpu, sec, addr, wd, r, e);
    chk(req, $sformatf("write err @%h", addr), {7'd0, e}, {7'd0, be});
  endtask

  task automatic rd_chk(input string req, input int cpu, input bit sec, input int addr);
    logic [7:0] r; logic e; logic [7:0] x; bit be;
    x = model_read(cpu, sec, addr);
    be = exp_bad(sec, addr);
    access(1'b1, 1'b0, cpu, sec, addr, 8'h00, r, e);
    chk(req, $sformatf("rdata cpu%0d @%h", cpu, addr), r, x);
    chk(req, $sformatf("read err @%h", addr), {7'd0, e}, {7'd0, be});
  endtask

  task automatic view_chk(input string req);
    logic [NUM_CPU*NUM_IRQ-1:0] x;
    for (int c = 0; c < NUM_CPU; c++)
      for (int n = 0; n < NUM_IRQ; n++) x[c*NUM_IRQ + n] = model[c][n];
    checks++;
    if (grp_view !== x) begin
      fails++;
      $display("FAIL %s grp_view actual=%h expected=%h", req, grp_view, x);
    end
  endtask

  task automatic t_reset();
    chk("R1", "rdata after reset", bus_rdata, 8'h00);
    chk("R1", "err after reset", {7'd0, bus_err}, 8'h00);
    view_chk("R1");
  endtask

  task automatic t_shared();
    cfg_arch_rev = 4'd2; cfg_sec_ext = 1'b0;
    wr_chk("R7", 0, 1'b0, 'h84, 8'hA5);
    rd_chk("R7", 2, 1'b0, 'h84);
    wr_chk("R3", 3, 1'b0, 'h8B, 8'h3C);
    rd_chk("R3", 1, 1'b0, 'h8B);
    view_chk("R9");
  endtask

  task automatic t_private();
    wr_chk("R6", 0, 1'b0, 'h80, 8'h11);
    wr_chk("R6", 1, 1'b0, 'h80, 8'h22);
    wr_chk("R6", 3, 1'b0, 'h83, 8'hF0);
    rd_chk("R6", 0, 1'b0, 'h80);
    rd_chk("R6", 1, 1'b0, 'h80);
    rd_chk("R6", 2, 1'b0, 'h80);
    rd_chk("R6", 3, 1'b0, 'h83);
    view_chk("R9");
  endtask

  task automatic t_gating();
    cfg_arch_rev = 4'd1; cfg_sec_ext = 1'b0;
    wr_chk("R4", 0, 1'b1, 'h84, 8'hFF);
    rd_chk("R4", 0, 1'b1, 'h84);
    rd_chk("R4", 0, 1'b1, 'h8C);
    view_chk("R4");
    cfg_sec_ext = 1'b1;
    wr_chk("R5", 1, 1'b0, 'h85, 8'hFF);
    rd_chk("R5", 1, 1'b0, 'h84);
    rd_chk("R5", 1, 1'b0, 'h8C);
    view_chk("R5");
    wr_chk("R5", 1, 1'b1, 'h85, 8'h0F);
    rd_chk("R5", 2, 1'b1, 'h85);
    cfg_arch_rev = 4'd2;
    wr_chk("R5", 0, 1'b0, 'h80, 8'hEE);
    rd_chk("R5", 0, 1'b1, 'h80);
    cfg_sec_ext = 1'b0;
  endtask

  task automatic t_errors();
    rd_chk("R8", 0, 1'b0, 'h10);
    wr_chk("R8", 0, 1'b0, 'h7F, 8'hFF);
    wr_chk("R8", 2, 1'b0, 'h80 + NUM_BYTES, 8'hFF);
    rd_chk("R8", 2, 1'b0, 'h80 + NUM_BYTES);
    view_chk("R8");
  endtask

  task automatic t_latency();
    logic [7:0] r; logic e;
    rd_chk("R2", 0, 1'b0, 'h84);
    @(negedge clk);
    chk("R2", "rdata one idle cycle after read", bus_rdata, 8'h00);
    chk("R8", "err one idle cycle after access", {7'd0, bus_err}, 8'h00);
    access(1'b0, 1'b1, 1, 1'b0, 'h86, 8'h5A, r, e);
    model_write(1, 1'b0, 'h86, 8'h5A);
    chk("R2", "rdata after write only", r, 8'h00);
  endtask

  task automatic t_rdwr();
    logic [7:0] r; logic e; logic [7:0] old;
    old = model_read(2, 1'b0, 'h86);
    access(1'b1, 1'b1, 2, 1'b0, 'h86, 8'hC3, r, e);
    model_write(2, 1'b0, 'h86, 8'hC3);
    chk("R10", "read during write returns old", r, old);
    rd_chk("R10", 0, 1'b0, 'h86);
    view_chk("R9");
  endtask

  initial begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int n = 0; n < NUM_IRQ; n++) model[c][n] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_shared();
    t_private();
    t_gating();
    t_errors();
    t_latency();
    t_rdwr();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule